// File: doc/BRIEF.md
# Machine-Check Error Bank Logger

This block keeps the error-logging state of a processor's machine-check architecture. It holds a parameterised number of error banks. Each bank has a control word, a status word, an address word and a misc word. Next to the banks sit one global status word and one global control word. A producer of hardware errors presents an injection request that carries a bank index, a status word, a global status word, an address and a misc value. The block checks that the request is well formed. It then decides whether the error is logged, folded into an overflow mark, escalated to a reset, or dropped.

Uncorrected errors must pass both the global enable word and the per-bank enable word. They are escalated to a reset request when machine checks are disabled or when one is already being handled. When logged, they raise the machine-check interrupt. Corrected errors never displace a pending uncorrected error; they only mark that error as overflowed. The block takes one request per cycle. Every outcome is visible one clock after the request. Control words are written through a narrow write port, and bank contents can be read back through a combinational read port.

Top module: `mcl_logger`

## Requirements
- R1: After reset every bank status, address and misc word and the global status are zero, every bank control and the global control are all ones, and no outcome pulse is high.
- R2: A request is dropped, with `req_drop` pulsed and no state changed, when `cap_banks` is zero, when `req_bank` is not below `cap_banks` or the built bank count, or when the status valid flag (bit 63) is clear. Reading an index beyond the built banks returns zero.
- R3: When the global status in-progress flag (bit 2) is set, a request whose action-required flag (bit 55) is clear and whose `req_uncond` is low is dropped.
- R4: An uncorrected request (bit 61 set) is dropped when the bank's control is not all ones, or when `cap_gctl_present` is high and the global control is not all ones. Controls have no effect on corrected requests.
- R5: An uncorrected request that passes R4 pulses `reset_req` and changes no bank when `mce_en` is low or the in-progress flag is set.
- R6: Otherwise an uncorrected request writes the bank's address, misc and status and the global status, and pulses `mce_irq`, all visible one cycle after the request.
- R7: Whenever a request's status is written into a bank whose valid flag is already set, the stored status also carries the overflow flag (bit 62).
- R8: A corrected request overwrites the bank's address, misc and status when the bank is empty or holds a corrected error, and it leaves the global status and all outcome pulses unchanged.
- R9: A corrected request aimed at a bank that holds a valid uncorrected error only sets the overflow flag of the stored status. Address and misc are kept.
- R10: A control write updates the selected bank control (`ctl_global` low) or the global control (`ctl_global` high) on the next edge. Each request produces at most one of `mce_irq`, `reset_req` and `req_drop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_banks | input | 8 | Advertised bank count |
| cap_gctl_present | input | 1 | Global control word is implemented |
| mce_en | input | 1 | Machine-check handling enabled |
| ctl_we | input | 1 | Control write strobe |
| ctl_global | input | 1 | Write targets the global control |
| ctl_idx | input | 8 | Bank index for a bank control write |
| ctl_wdata | input | 64 | Control write data |
| req_valid | input | 1 | Injection request strobe |
| req_bank | input | 8 | Target bank index |
| req_uncond | input | 1 | Bypass the in-progress ignore rule |
| req_status | input | 64 | Bank status value to log |
| req_gstatus | input | 64 | Global status value for an uncorrected log |
| req_addr | input | 64 | Error address |
| req_misc | input | 64 | Error misc information |
| rd_sel | input | 8 | Bank index for readback |
| rd_ctl | output | 64 | Control of the selected bank |
| rd_status | output | 64 | Status of the selected bank |
| rd_addr | output | 64 | Address of the selected bank |
| rd_misc | output | 64 | Misc of the selected bank |
| gstat | output | 64 | Global status |
| gctl | output | 64 | Global control |
| mce_irq | output | 1 | Machine-check interrupt pulse |
| reset_req | output | 1 | Reset escalation pulse |
| req_drop | output | 1 | Request dropped pulse |

## Verification
The assertions assume that `req_valid` and `ctl_we` are never unknown after reset. They also assume that a control write and a request to the same bank in one cycle are both legal, with the request seeing the old control. The stimulus changes inputs only on falling edges, holds each request for exactly one cycle, and drives every request field to a defined value even when the request is expected to be dropped. As a result, the bank-hold and overflow-only properties see only clean one-cycle strobes.

// File: rtl/mcl_pkg.sv
package mcl_pkg;

  localparam int STW       = 64;
  localparam int B_VAL     = 63;
  localparam int B_OVER    = 62;
  localparam int B_UC      = 61;
  localparam int B_AR      = 55;
  localparam int G_INPROG  = 2;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_DROP,
    ACT_RESET,
    ACT_LOG_UC,
    ACT_LOG_CE,
    ACT_MARK_OVER
  } act_e;

  // Decision for a request that already passed the range and valid screen.
  function automatic act_e mcl_decide(
    input logic [STW-1:0] st,
    input logic           uncond,
    input logic           inprog,
    input logic           gctl_ok,
    input logic           bctl_ok,
    input logic           mce_en,
    input logic [STW-1:0] old_st
  );
    act_e a;
    if (inprog && !st[B_AR] && !uncond)           a = ACT_DROP;
    else if (st[B_UC]) begin
      if (!gctl_ok || !bctl_ok)                   a = ACT_DROP;
      else if (!mce_en || inprog)                 a = ACT_RESET;
      else                                        a = ACT_LOG_UC;
    end
    else if (!old_st[B_VAL] || !old_st[B_UC])     a = ACT_LOG_CE;
    else                                          a = ACT_MARK_OVER;
    return a;
  endfunction

  // New status with the overflow flag folded in when the slot was occupied.
  function automatic logic [STW-1:0] mcl_fold_over(
    input logic [STW-1:0] new_st,
    input logic [STW-1:0] old_st
  );
    logic [STW-1:0] r;
    r = new_st;
    if (old_st[B_VAL]) r[B_OVER] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/mcl_screen.sv
module mcl_screen
  import mcl_pkg::*;
#(
  parameter int N_BANKS = 4
) (
  input  logic           req_valid,
  input  logic [7:0]     req_bank,
  input  logic           req_uncond,
  input  logic [STW-1:0] req_status,
  input  logic [7:0]     cap_banks,
  input  logic           cap_gctl_present,
  input  logic           mce_en,
  input  logic [STW-1:0] gctl_q,
  input  logic [STW-1:0] gstat_q,
  input  logic [STW-1:0] bank_ctl,
  input  logic [STW-1:0] bank_st,
  output act_e           act
);

  localparam logic [8:0] BUILT = 9'(N_BANKS);

  logic in_range;
  logic gctl_ok;
  logic bctl_ok;

  assign in_range = (cap_banks != 8'd0) && (req_bank < cap_banks) &&
                    ({1'b0, req_bank} < BUILT);
  assign gctl_ok  = !cap_gctl_present || (&gctl_q);
  assign bctl_ok  = &bank_ctl;

  always_comb begin
    if (!req_valid)                            act = ACT_NONE;
    else if (!in_range || !req_status[B_VAL])  act = ACT_DROP;
    else act = mcl_decide(req_status, req_uncond, gstat_q[G_INPROG],
                          gctl_ok, bctl_ok, mce_en, bank_st);
  end

endmodule

// File: rtl/mcl_bank.sv
module mcl_bank
  import mcl_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_we,
  input  logic [STW-1:0] ctl_wdata,
  input  logic           log_we,
  input  logic [STW-1:0] log_status,
  input  logic [STW-1:0] log_addr,
  input  logic [STW-1:0] log_misc,
  input  logic           over_we,
  output logic [STW-1:0] ctl,
  output logic [STW-1:0] status,
  output logic [STW-1:0] addr,
  output logic [STW-1:0] misc
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl    <= '1;
      status <= '0;
      addr   <= '0;
      misc   <= '0;
    end else begin
      if (ctl_we) ctl <= ctl_wdata;
      if (log_we) begin
        status <= log_status;
        addr   <= log_addr;
        misc   <= log_misc;
      end else if (over_we) begin
        status[B_OVER] <= 1'b1;
      end
    end
  end

  // R2: a bank not addressed by a log or overflow update keeps its contents
  p_bank_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !log_we && !over_we |=> $stable(status) && $stable(addr) && $stable(misc));

  // R9: an overflow-only update touches nothing but the overflow flag
  p_over_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    over_we && !log_we |=> status[B_OVER] && $stable(addr) && $stable(misc) &&
      (status[B_OVER-1:0] == $past(status[B_OVER-1:0])) &&
      (status[STW-1:B_OVER+1] == $past(status[STW-1:B_OVER+1])));

  // R6: anything logged into a bank is a valid entry
  p_log_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    log_we && log_status[B_VAL] |=> status[B_VAL]);

endmodule

// File: rtl/mcl_logger.sv
module mcl_logger
  import mcl_pkg::*;
#(
  parameter int N_BANKS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [7:0]     cap_banks,
  input  logic           cap_gctl_present,
  input  logic           mce_en,
  input  logic           ctl_we,
  input  logic           ctl_global,
  input  logic [7:0]     ctl_idx,
  input  logic [63:0]    ctl_wdata,
  input  logic           req_valid,
  input  logic [7:0]     req_bank,
  input  logic           req_uncond,
  input  logic [63:0]    req_status,
  input  logic [63:0]    req_gstatus,
  input  logic [63:0]    req_addr,
  input  logic [63:0]    req_misc,
  input  logic [7:0]     rd_sel,
  output logic [63:0]    rd_ctl,
  output logic [63:0]    rd_status,
  output logic [63:0]    rd_addr,
  output logic [63:0]    rd_misc,
  output logic [63:0]    gstat,
  output logic [63:0]    gctl,
  output logic           mce_irq,
  output logic           reset_req,
  output logic           req_drop
);

  logic [STW-1:0] bk_ctl  [N_BANKS];
  logic [STW-1:0] bk_st   [N_BANKS];
  logic [STW-1:0] bk_addr [N_BANKS];
  logic [STW-1:0] bk_misc [N_BANKS];

  logic [STW-1:0] sel_ctl;
  logic [STW-1:0] sel_st;
  logic [STW-1:0] fold_st;
  logic [STW-1:0] gstat_q;
  logic [STW-1:0] gctl_q;
  logic           irq_q, rst_q, drop_q;
  logic           do_log, do_over;
  act_e           act;

  // Addressed bank for the request.
  always_comb begin
    sel_ctl = '1;
    sel_st  = '0;
    for (int b = 0; b < N_BANKS; b++) begin
      if (req_bank == 8'(b)) begin
        sel_ctl = bk_ctl[b];
        sel_st  = bk_st[b];
      end
    end
  end

  mcl_screen #(.N_BANKS(N_BANKS)) u_screen (
    .req_valid        (req_valid),
    .req_bank         (req_bank),
    .req_uncond       (req_uncond),
    .req_status       (req_status),
    .cap_banks        (cap_banks),
    .cap_gctl_present (cap_gctl_present),
    .mce_en           (mce_en),
    .gctl_q           (gctl_q),
    .gstat_q          (gstat_q),
    .bank_ctl         (sel_ctl),
    .bank_st          (sel_st),
    .act              (act)
  );

  assign do_log  = (act == ACT_LOG_UC) || (act == ACT_LOG_CE);
  assign do_over = (act == ACT_MARK_OVER);
  assign fold_st = mcl_fold_over(req_status, sel_st);

  for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
    logic hit;
    assign hit = (req_bank == 8'(g));
    mcl_bank u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_we     (ctl_we && !ctl_global && (ctl_idx == 8'(g))),
      .ctl_wdata  (ctl_wdata),
      .log_we     (do_log && hit),
      .log_status (fold_st),
      .log_addr   (req_addr),
      .log_misc   (req_misc),
      .over_we    (do_over && hit),
      .ctl        (bk_ctl[g]),
      .status     (bk_st[g]),
      .addr       (bk_addr[g]),
      .misc       (bk_misc[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gstat_q <= '0;
      gctl_q  <= '1;
      irq_q   <= 1'b0;
      rst_q   <= 1'b0;
      drop_q  <= 1'b0;
    end else begin
      if (ctl_we && ctl_global) gctl_q <= ctl_wdata;
      if (act == ACT_LOG_UC)    gstat_q <= req_gstatus;
      irq_q  <= (act == ACT_LOG_UC);
      rst_q  <= (act == ACT_RESET);
      drop_q <= (act == ACT_DROP);
    end
  end

  // Readback; an index beyond the built banks reads as zero.
  always_comb begin
    rd_ctl    = '0;
    rd_status = '0;
    rd_addr   = '0;
    rd_misc   = '0;
    for (int b = 0; b < N_BANKS; b++) begin
      if (rd_sel == 8'(b)) begin
        rd_ctl    = bk_ctl[b];
        rd_status = bk_st[b];
        rd_addr   = bk_addr[b];
        rd_misc   = bk_misc[b];
      end
    end
  end

  assign gstat     = gstat_q;
  assign gctl      = gctl_q;
  assign mce_irq   = irq_q;
  assign reset_req = rst_q;
  assign req_drop  = drop_q;

  // R10: one outcome per request at most
  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mce_irq, reset_req, req_drop}));

  // R6: an uncorrected log raises the interrupt and captures global status
  p_uc_log_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_LOG_UC |=> mce_irq && (gstat == $past(req_gstatus)));

  // R5: escalation leaves the global status alone
  p_escalate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_RESET |=> reset_req && $stable(gstat));

  // R8: corrected handling never touches global status or raises a pulse
  p_ce_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_LOG_CE || act == ACT_MARK_OVER) |=>
      !mce_irq && !reset_req && !req_drop && $stable(gstat));

endmodule

// File: tb/mcl_logger_test.sv
module mcl_logger_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] V = 64'h8000_0000_0000_0000;
  localparam logic [63:0] O = 64'h4000_0000_0000_0000;
  localparam logic [63:0] U = 64'h2000_0000_0000_0000;
  localparam logic [63:0] A = 64'h0080_0000_0000_0000;
  localparam logic [63:0] ONES = '1;

  typedef struct packed {
    logic [7:0]  bank;
    logic [63:0] st;
    logic [63:0] gs;
    logic [63:0] addr;
    logic        unc;
    logic [1:0]  out;      // 0 none, 1 irq, 2 reset, 3 drop
    logic [63:0] exp_st;
    logic [63:0] exp_gs;
    logic [63:0] exp_addr;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'd0, V|64'h11,   64'h0, 64'h1000, 1'b0, 2'd0, V|64'h11,     64'h0, 64'h1000},
    '{8'd0, V|64'h22,   64'h0, 64'h2000, 1'b0, 2'd0, V|O|64'h22,   64'h0, 64'h2000},
    '{8'd1, V|U|64'h33, 64'h5, 64'h3000, 1'b0, 2'd1, V|U|64'h33,   64'h5, 64'h3000},
    '{8'd1, V|64'h44,   64'h0, 64'h4000, 1'b0, 2'd3, V|U|64'h33,   64'h5, 64'h3000},
    '{8'd1, V|64'h44,   64'h0, 64'h5000, 1'b1, 2'd0, V|U|O|64'h33, 64'h5, 64'h3000},
    '{8'd2, V|U|A|64'h55, 64'h0, 64'h6000, 1'b0, 2'd2, 64'h0,      64'h5, 64'h0},
    '{8'd2, V|A|64'h66, 64'h0, 64'h7000, 1'b0, 2'd0, V|A|64'h66,   64'h5, 64'h7000},
    '{8'd3, U|64'h01,   64'h0, 64'h8000, 1'b0, 2'd3, 64'h0,        64'h5, 64'h0},
    '{8'd4, V|64'h09,   64'h0, 64'h9000, 1'b0, 2'd3, 64'h0,        64'h5, 64'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cap_banks;
  logic        cap_gctl_present;
  logic        mce_en;
  logic        ctl_we, ctl_global;
  logic [7:0]  ctl_idx;
  logic [63:0] ctl_wdata;
  logic        req_valid;
  logic [7:0]  req_bank;
  logic        req_uncond;
  logic [63:0] req_status, req_gstatus, req_addr, req_misc;
  logic [7:0]  rd_sel;
  logic [63:0] rd_ctl, rd_status, rd_addr, rd_misc, gstat, gctl;
  logic        mce_irq, reset_req, req_drop;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcl_logger #(.N_BANKS(4)) uut (
    .clk(clk), .rst_n(rst_n), .cap_banks(cap_banks),
    .cap_gctl_present(cap_gctl_present), .mce_en(mce_en),
    .ctl_we(ctl_we), .ctl_global(ctl_global), .ctl_idx(ctl_idx),
    .ctl_wdata(ctl_wdata), .req_valid(req_valid), .req_bank(req_bank),
    .req_uncond(req_uncond), .req_status(req_status),
    .req_gstatus(req_gstatus), .req_addr(req_addr), .req_misc(req_misc),
    .rd_sel(rd_sel), .rd_ctl(rd_ctl), .rd_status(rd_status),
    .rd_addr(rd_addr), .rd_misc(rd_misc), .gstat(gstat), .gctl(gctl),
    .mce_irq(mce_irq), .reset_req(reset_req), .req_drop(req_drop)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] outcome();
    return mce_irq ? 2'd1 : reset_req ? 2'd2 : req_drop ? 2'd3 : 2'd0;
  endfunction

  // Present one request for one cycle; on return the result is visible.
  task automatic send(input logic [7:0] b, input logic [63:0] st,
                      input logic [63:0] gs, input logic [63:0] ad,
                      input logic unc);
    @(negedge clk);
    req_valid = 1'b1; req_bank = b; req_status = st; req_gstatus = gs;
    req_addr = ad; req_misc = ad + 64'd1; req_uncond = unc;
    @(negedge clk);
    req_valid = 1'b0;
    rd_sel = b;
    #1;
  endtask

  task automatic wr_ctl(input logic glob, input logic [7:0] idx, input logic [63:0] d);
    @(negedge clk);
    ctl_we = 1'b1; ctl_global = glob; ctl_idx = idx; ctl_wdata = d;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    cap_banks = 8'd4; cap_gctl_present = 1'b1; mce_en = 1'b1;
    ctl_we = 1'b0; ctl_global = 1'b0; ctl_idx = 8'd0; ctl_wdata = '0;
    req_valid = 1'b0; req_bank = 8'd0; req_uncond = 1'b0;
    req_status = '0; req_gstatus = '0; req_addr = '0; req_misc = '0;
    rd_sel = 8'd0;
    do_reset();

    // R1: reset state
    for (int b = 0; b < 4; b++) begin
      rd_sel = 8'(b); #1;
      chk("R1 bank status", rd_status, 64'h0);
      chk("R1 bank addr",   rd_addr,   64'h0);
      chk("R1 bank ctl",    rd_ctl,    ONES);
    end
    chk("R1 gstat", gstat, 64'h0);
    chk("R1 gctl",  gctl,  ONES);
    chk("R1 pulses", {61'd0, mce_irq, reset_req, req_drop}, 64'h0);

    // Table walk: R8 R7 R6 R3 R9 R5 R2
    for (int i = 0; i < NV; i++) begin
      send(VECS[i].bank, VECS[i].st, VECS[i].gs, VECS[i].addr, VECS[i].unc);
      chk($sformatf("R6/R8 row %0d outcome", i), 64'(outcome()), 64'(VECS[i].out));
      chk($sformatf("R7/R9 row %0d status", i), rd_status, VECS[i].exp_st);
      chk($sformatf("R9 row %0d addr", i), rd_addr, VECS[i].exp_addr);
      chk($sformatf("R8 row %0d misc", i), rd_misc,
          (VECS[i].exp_addr == 64'h0) ? 64'h0 : VECS[i].exp_addr + 64'd1);
      chk($sformatf("R6 row %0d gstat", i), gstat, VECS[i].exp_gs);
    end

    // Directed corner cases
    do_reset();

    // R10 / R4: global control blocks uncorrected reporting when present
    wr_ctl(1'b1, 8'd0, 64'h0);
    chk("R10 gctl write", gctl, 64'h0);
    send(8'd0, V|U|64'h71, 64'h1, 64'hA000, 1'b0);
    chk("R4 gctl drop outcome", 64'(outcome()), 64'd3);
    chk("R4 gctl drop status", rd_status, 64'h0);

    // R4: global control ignored when not implemented
    cap_gctl_present = 1'b0;
    send(8'd0, V|U|64'h72, 64'h1, 64'hB000, 1'b0);
    chk("R4 no gctl irq", 64'(outcome()), 64'd1);
    chk("R6 uc status", rd_status, V|U|64'h72);
    chk("R6 uc addr", rd_addr, 64'hB000);
    chk("R6 uc gstat", gstat, 64'h1);
    cap_gctl_present = 1'b1;
    wr_ctl(1'b1, 8'd0, ONES);

    // R7: uncorrected over a valid entry sets overflow
    send(8'd0, V|U|64'h73, 64'h1, 64'hC000, 1'b0);
    chk("R7 uc over outcome", 64'(outcome()), 64'd1);
    chk("R7 uc over status", rd_status, V|U|O|64'h73);

    // R4: bank control gates uncorrected only
    wr_ctl(1'b0, 8'd1, 64'h0);
    rd_sel = 8'd1; #1;
    chk("R10 bank ctl write", rd_ctl, 64'h0);
    send(8'd1, V|U|64'h74, 64'h1, 64'hD000, 1'b0);
    chk("R4 bctl drop outcome", 64'(outcome()), 64'd3);
    chk("R4 bctl drop status", rd_status, 64'h0);
    send(8'd1, V|64'h75, 64'h1, 64'hE000, 1'b0);
    chk("R4 bctl ce outcome", 64'(outcome()), 64'd0);
    chk("R4 bctl ce status", rd_status, V|64'h75);

    // R5: machine checks disabled escalates to reset
    mce_en = 1'b0;
    send(8'd2, V|U|64'h76, 64'h1, 64'hF000, 1'b0);
    chk("R5 disabled outcome", 64'(outcome()), 64'd2);
    chk("R5 disabled status", rd_status, 64'h0);
    chk("R5 disabled gstat", gstat, 64'h1);
    mce_en = 1'b1;

    // R2: zero capability count rejects everything
    cap_banks = 8'd0;
    send(8'd0, V|64'h77, 64'h1, 64'h1234, 1'b0);
    chk("R2 zero cap outcome", 64'(outcome()), 64'd3);
    chk("R2 zero cap status", rd_status, V|U|O|64'h73);
    cap_banks = 8'd4;

    done = 1;
    summary();
    $finish;
  end

endmodule